// File: doc/BRIEF.md
# Phased SPI Master Transaction Engine

This block is an SPI master that clocks out a single framed transaction assembled from up to five optional phases. The phases are command, address, transmit data, dummy and receive data. Software fills a small register set with the phase enables, the length of each phase and the command, address and transmit values, and then writes the start bit. The engine lowers chip select, runs every enabled phase in turn and raises chip select again. The start bit reads as a busy flag until the frame is over, and the received bits then appear in a 32-bit result word.

The serial clock runs in mode 0: it idles low, the input is sampled on the rising edge and the output changes after the falling edge. It advances only on cycles where the external `clk_en` strobe is high, so each bit takes two strobes. The position of the dummy phase depends on whether a receive phase is enabled. Without a receive phase, the dummy bits come before the transmit data. With a receive phase, they come between the transmit data and the received data.

Top module: `phased_spi_master`

## Requirements
- R1: After reset, chip select is high, the serial clock and MOSI are low, the busy bit reads 0 and the result word (index 7) reads 0.
- R2: Writing a word with bit 18 set to index 0 while idle starts a frame. Bit 18 of index 0 reads 1 for as long as the frame runs and returns to 0 by itself once chip select has risen again.
- R3: When the receive phase is enabled, the enabled phases run in this order: command, address, transmit, dummy, receive.
- R4: When the receive phase is disabled, the enabled phases run in this order: command, address, dummy, transmit.
- R5: Index 1 holds the phase enables: bit0 command, bit1 address, bit2 transmit, bit3 dummy, bit4 receive. A disabled phase adds no clocks. An enabled phase runs for its length field plus one bits. The length fields are: index 2 bits [3:0] command, [13:8] address, [23:16] dummy; index 3 bits [8:0] transmit, [24:16] receive. A frame with no phase enabled produces no clocks and still clears busy.
- R6: Command (index 4, 16 bits), address (index 5) and transmit data (index 6) are sent MSB first from their low-justified bits. Positions above the value width are sent as 0. For example, a 3-bit command 101, a 9-bit address 0x1F3 and 8 data bits 0xCC give the stream 0xBF3CC.
- R7: When index 1 bit5 is set, the transmit phase sends the 32-bit word lowest byte first, MSB first within each byte. Any bits past 32 are sent as 0.
- R8: When index 1 bit6 is clear, the first received bit lands in bit 31 and later bits fill downward. With fewer than 32 bits, the bits below are 0. With more than 32 bits, the word keeps the last 32 bits received.
- R9: When index 1 bit6 is set, the result word is the byte-reversed form of the R8 word.
- R10: MOSI is low during the dummy and receive phases, and MISO has no effect during the dummy phase.
- R11: A start written while busy is ignored. Register writes made during a frame do not change that frame.
- R12: The serial clock changes only on cycles after `clk_en` was high. It is high only while chip select is low, and MOSI holds still while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Bit-rate strobe; one serial clock edge per strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |
| cs_n | output | 1 | Chip select, active low, spans the whole frame |

## Verification
A wrong phase pointer or bit counter appears at once as a misplaced bit in the MOSI stream. The bench compares that stream bit by bit against a scoreboard at every rising serial clock edge, so the error is caught at the first wrong bit rather than at the end of the frame. A fault in the receive path shows only in the result word, which the bench reads as soon as busy clears. A broken start guard or configuration snapshot shows as extra clocks or altered bits in the frame that was running when the second start or the new values were written.

// File: rtl/spi_phase_pkg.sv
package spi_phase_pkg;
  localparam int WORD_W  = 32;
  localparam int CMD_W   = 16;
  localparam int ADDR_W  = 32;
  localparam int CMD_LW  = 4;
  localparam int ADDR_LW = 6;
  localparam int DUM_LW  = 8;
  localparam int DAT_LW  = 9;
  localparam int CNT_W   = 9;
  localparam int NSLOT   = 5;
  localparam int WIDE_W  = 2 * WORD_W;

  localparam logic [2:0] SLOT_END = 3'd5;
  localparam logic [2:0] SLOT_ARM = 3'd6;

  typedef enum logic [2:0] {
    PH_CMD   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_OUT   = 3'd2,
    PH_DUMMY = 3'd3,
    PH_IN    = 3'd4,
    PH_NONE  = 3'd5
  } phase_e;

  typedef struct packed {
    logic               cmd_en;
    logic               addr_en;
    logic               out_en;
    logic               dum_en;
    logic               in_en;
    logic               tx_lo;
    logic               rx_lo;
    logic [CMD_LW-1:0]  cmd_len;
    logic [ADDR_LW-1:0] addr_len;
    logic [DUM_LW-1:0]  dum_len;
    logic [DAT_LW-1:0]  out_len;
    logic [DAT_LW-1:0]  in_len;
    logic [CMD_W-1:0]   cmd_val;
    logic [ADDR_W-1:0]  addr_val;
    logic [WORD_W-1:0]  tx_word;
  } cfg_t;

  // Order of phases within a frame; the dummy slot moves with the read phase.
  function automatic phase_e phase_at(input logic [2:0] slot, input logic rx_on);
    case (slot)
      3'd0:    phase_at = PH_CMD;
      3'd1:    phase_at = PH_ADDR;
      3'd2:    phase_at = rx_on ? PH_OUT : PH_DUMMY;
      3'd3:    phase_at = rx_on ? PH_DUMMY : PH_OUT;
      3'd4:    phase_at = rx_on ? PH_IN : PH_NONE;
      default: phase_at = PH_NONE;
    endcase
  endfunction

  function automatic logic phase_on(input phase_e p, input cfg_t c);
    case (p)
      PH_CMD:   phase_on = c.cmd_en;
      PH_ADDR:  phase_on = c.addr_en;
      PH_OUT:   phase_on = c.out_en;
      PH_DUMMY: phase_on = c.dum_en;
      PH_IN:    phase_on = c.in_en;
      default:  phase_on = 1'b0;
    endcase
  endfunction

  // Bit count minus one for a phase.
  function automatic logic [CNT_W-1:0] phase_len(input phase_e p, input cfg_t c);
    case (p)
      PH_CMD:   phase_len = CNT_W'(c.cmd_len);
      PH_ADDR:  phase_len = CNT_W'(c.addr_len);
      PH_OUT:   phase_len = CNT_W'(c.out_len);
      PH_DUMMY: phase_len = CNT_W'(c.dum_len);
      PH_IN:    phase_len = CNT_W'(c.in_len);
      default:  phase_len = '0;
    endcase
  endfunction

  // First enabled slot after 'from' (or from the top when restart is set).
  function automatic logic [2:0] next_slot(input logic [2:0] from, input logic restart,
                                           input cfg_t c);
    logic [2:0] r;
    r = SLOT_END;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if ((restart || 3'(s) > from) && phase_on(phase_at(3'(s), c.in_en), c))
        r = 3'(s);
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] byte_swap(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WORD_W / 8; b++)
      r[8*b +: 8] = w[WORD_W - 8*(b+1) +: 8];
    return r;
  endfunction

  // Serial bit for the current phase; cnt is the low-justified bit index.
  function automatic logic tx_bit(input phase_e p, input logic [CNT_W-1:0] cnt,
                                  input cfg_t c);
    logic [WIDE_W-1:0] t;
    logic [CNT_W-1:0]  elapsed;
    t = '0;
    elapsed = c.out_len - cnt;
    case (p)
      PH_CMD:  t = WIDE_W'(c.cmd_val) >> cnt;
      PH_ADDR: t = WIDE_W'(c.addr_val) >> cnt;
      PH_OUT: begin
        if (c.tx_lo) t = WIDE_W'(byte_swap(c.tx_word) << elapsed) >> (WORD_W - 1);
        else         t = WIDE_W'(c.tx_word) >> cnt;
      end
      default: t = '0;
    endcase
    return t[0];
  endfunction

  // Place the collected bits in the result word.
  function automatic logic [WORD_W-1:0] rx_final(input logic [WORD_W-1:0] sh,
                                                 input logic [DAT_LW-1:0] len_m1,
                                                 input logic lo_first);
    logic [DAT_LW:0]   n;
    logic [WORD_W-1:0] w;
    n = {1'b0, len_m1} + 1'b1;
    if (n < (DAT_LW+1)'(WORD_W)) w = sh << ((DAT_LW+1)'(WORD_W) - n);
    else                         w = sh;
    return lo_first ? byte_swap(w) : w;
  endfunction
endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_phase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic [WORD_W-1:0] rx_word,
  output logic              start_acc,
  output cfg_t              shadow
);
  localparam logic [2:0] IX_CTRL = 3'd0;
  localparam logic [2:0] IX_MODE = 3'd1;
  localparam logic [2:0] IX_LENA = 3'd2;
  localparam logic [2:0] IX_LENB = 3'd3;
  localparam logic [2:0] IX_CMD  = 3'd4;
  localparam logic [2:0] IX_ADDR = 3'd5;
  localparam logic [2:0] IX_TX   = 3'd6;
  localparam logic [2:0] IX_RX   = 3'd7;
  localparam int GO_BIT = 18;

  cfg_t live;

  assign start_acc = reg_wr && (reg_addr == IX_CTRL) && reg_wdata[GO_BIT] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        IX_MODE: begin
          live.cmd_en  <= reg_wdata[0];
          live.addr_en <= reg_wdata[1];
          live.out_en  <= reg_wdata[2];
          live.dum_en  <= reg_wdata[3];
          live.in_en   <= reg_wdata[4];
          live.tx_lo   <= reg_wdata[5];
          live.rx_lo   <= reg_wdata[6];
        end
        IX_LENA: begin
          live.cmd_len  <= reg_wdata[CMD_LW-1:0];
          live.addr_len <= reg_wdata[8 +: ADDR_LW];
          live.dum_len  <= reg_wdata[16 +: DUM_LW];
        end
        IX_LENB: begin
          live.out_len <= reg_wdata[DAT_LW-1:0];
          live.in_len  <= reg_wdata[16 +: DAT_LW];
        end
        IX_CMD:  live.cmd_val  <= reg_wdata[CMD_W-1:0];
        IX_ADDR: live.addr_val <= reg_wdata[ADDR_W-1:0];
        IX_TX:   live.tx_word  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow <= '0;
    else if (start_acc) shadow <= live;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      IX_CTRL: reg_rdata[GO_BIT] = busy;
      IX_MODE: reg_rdata[6:0] = {live.rx_lo, live.tx_lo, live.in_en, live.dum_en,
                                 live.out_en, live.addr_en, live.cmd_en};
      IX_LENA: begin
        reg_rdata[CMD_LW-1:0]   = live.cmd_len;
        reg_rdata[8 +: ADDR_LW] = live.addr_len;
        reg_rdata[16 +: DUM_LW] = live.dum_len;
      end
      IX_LENB: begin
        reg_rdata[DAT_LW-1:0]   = live.out_len;
        reg_rdata[16 +: DAT_LW] = live.in_len;
      end
      IX_CMD:  reg_rdata[CMD_W-1:0]  = live.cmd_val;
      IX_ADDR: reg_rdata[ADDR_W-1:0] = live.addr_val;
      IX_TX:   reg_rdata = live.tx_word;
      IX_RX:   reg_rdata = rx_word;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_phase_seq.sv
module spi_phase_seq
  import spi_phase_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clk_en,
  input  logic   start_acc,
  input  cfg_t   cfg,
  output logic   busy,
  output logic   sclk,
  output logic   mosi,
  output logic   sample_tick,
  output logic   frame_end,
  output phase_e cur_phase
);
  logic [2:0]       slot;
  logic [2:0]       nxt;
  logic [CNT_W-1:0] cnt;
  phase_e           nxt_ph;

  assign cur_phase   = phase_at(slot, cfg.in_en);
  assign nxt         = next_slot(slot, slot == SLOT_ARM, cfg);
  assign nxt_ph      = phase_at(nxt, cfg.in_en);
  assign frame_end   = busy && (slot == SLOT_END);
  assign sample_tick = busy && clk_en && !sclk && (cur_phase == PH_IN);
  assign mosi        = busy ? tx_bit(cur_phase, cnt, cfg) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sclk <= 1'b0;
      slot <= SLOT_END;
      cnt  <= '0;
    end else if (start_acc) begin
      busy <= 1'b1;
      sclk <= 1'b0;
      slot <= SLOT_ARM;
      cnt  <= '0;
    end else if (busy) begin
      if (slot == SLOT_ARM) begin
        slot <= nxt;
        cnt  <= phase_len(nxt_ph, cfg);
      end else if (slot == SLOT_END) begin
        busy <= 1'b0;
      end else if (clk_en) begin
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (cnt == '0) begin
            slot <= nxt;
            cnt  <= phase_len(nxt_ph, cfg);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_rx_collect.sv
module spi_rx_collect
  import spi_phase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_acc,
  input  logic              sample_tick,
  input  logic              miso,
  input  logic              frame_end,
  input  logic              in_en,
  input  logic              rx_lo,
  input  logic [DAT_LW-1:0] in_len,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sh <= '0;
    else if (start_acc)   sh <= '0;
    else if (sample_tick) sh <= {sh[WORD_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rx_word <= '0;
    else if (frame_end && in_en) rx_word <= rx_final(sh, in_len, rx_lo);
  end
endmodule

// File: rtl/phased_spi_master.sv
module phased_spi_master
  import spi_phase_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clk_en,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);
  logic              busy;
  logic              start_acc;
  logic              sample_tick;
  logic              frame_end;
  phase_e            cur_phase;
  cfg_t              shadow;
  logic [WORD_W-1:0] rx_word;

  assign cs_n = ~busy;

  spi_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .rx_word(rx_word), .start_acc(start_acc), .shadow(shadow)
  );

  spi_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start_acc(start_acc),
    .cfg(shadow), .busy(busy), .sclk(sclk), .mosi(mosi),
    .sample_tick(sample_tick), .frame_end(frame_end), .cur_phase(cur_phase)
  );

  spi_rx_collect u_rx (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .sample_tick(sample_tick),
    .miso(miso), .frame_end(frame_end), .in_en(shadow.in_en),
    .rx_lo(shadow.rx_lo), .in_len(shadow.in_len), .rx_word(rx_word)
  );
endmodule

// File: rtl/spi_phase_chk.sv
module spi_phase_chk
  import spi_phase_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   clk_en,
  input logic   busy,
  input logic   sclk,
  input logic   mosi,
  input logic   cs_n,
  input phase_e cur_phase,
  input cfg_t   shadow
);
  // R12
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R12
  sclk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) || $fell(sclk)) |-> $past(clk_en));

  // R12
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R10
  quiet_mosi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cur_phase == PH_DUMMY || cur_phase == PH_IN)) |-> !mosi);

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy)) |-> $stable(shadow));

  // R2
  end_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !sclk);
endmodule

bind phased_spi_master spi_phase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .busy(busy), .sclk(sclk),
  .mosi(mosi), .cs_n(cs_n), .cur_phase(cur_phase), .shadow(shadow)
);

// File: tb/tb_phased_spi_master.sv
module tb_phased_spi_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk, mosi, cs_n;
  logic        miso = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  logic exp_q[$];
  string cur_tag = "R1";
  logic [127:0] resp = '0;
  int bitpos = 0;
  logic [1:0] en_div = '0;
  logic sclk_q = 1'b0, cs_q = 1'b1, en_q = 1'b0;

  phased_spi_master dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) en_div <= (en_div == 2'd2) ? 2'd0 : en_div + 2'd1;
  assign clk_en = (en_div == 2'd2);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: serial target model and scoreboard consumer.
  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk !== sclk_q) begin
        n_cmp++;
        if (!en_q || cs_n) begin
          n_bad++;
          $display("FAIL R12 actual sclk edge en=%b cs_n=%b expected en=1 cs_n=0", en_q, cs_n);
        end
      end
      if (cs_q && !cs_n) begin
        bitpos = 0;
        miso = resp[127];
      end
      if (sclk && !sclk_q) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL %s actual extra bit %b expected no clock", cur_tag, mosi);
        end else begin
          logic e;
          e = exp_q.pop_front();
          if (mosi !== e) begin
            n_bad++;
            $display("FAIL %s actual mosi %b expected %b at bit %0d", cur_tag, mosi, e, bitpos);
          end
        end
        bitpos++;
        miso = (bitpos < 128) ? resp[127 - bitpos] : 1'b0;
      end
    end
    sclk_q = sclk;
    cs_q   = cs_n;
    en_q   = clk_en;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic push_val(input logic [63:0] v, input int n);
    for (int k = n - 1; k >= 0; k--) exp_q.push_back(k < 64 ? v[k] : 1'b0);
  endtask

  task automatic push_lo(input logic [31:0] d, input int n);
    logic [31:0] sw;
    sw = {d[7:0], d[15:8], d[23:16], d[31:24]};
    for (int i = 0; i < n; i++) exp_q.push_back(i < 32 ? sw[31 - i] : 1'b0);
  endtask

  task automatic push_zero(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(1'b0);
  endtask

  function automatic logic [31:0] exp_rx(input logic [127:0] r, input int p, input int n,
                                         input logic lo);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < n; i++) w = {w[30:0], r[127 - (p + i)]};
    if (n < 32) w = w << (32 - n);
    if (lo) w = {w[7:0], w[15:8], w[23:16], w[31:24]};
    return w;
  endfunction

  // Driver: program registers and push the expected stream. Returns read start bit.
  task automatic setup_tx(input logic [6:0] mode, input int cl, input int al, input int dl,
                          input int ol, input int il, input logic [15:0] cv,
                          input logic [31:0] av, input logic [31:0] td,
                          input logic [127:0] rsp, input string tag, output int rx_at);
    int p;
    p = 0;
    resp = rsp;
    cur_tag = tag;
    if (mode[0]) begin push_val({48'd0, cv}, cl); p += cl; end
    if (mode[1]) begin push_val({32'd0, av}, al); p += al; end
    if (mode[4]) begin
      if (mode[2]) begin
        if (mode[5]) push_lo(td, ol); else push_val({32'd0, td}, ol);
        p += ol;
      end
      if (mode[3]) begin push_zero(dl); p += dl; end
      push_zero(il);
    end else begin
      if (mode[3]) begin push_zero(dl); p += dl; end
      if (mode[2]) begin
        if (mode[5]) push_lo(td, ol); else push_val({32'd0, td}, ol);
      end
    end
    rx_at = p;
    wr(3'd1, {25'd0, mode});
    wr(3'd2, 32'(((dl - 1) & 255) << 16 | ((al - 1) & 63) << 8 | ((cl - 1) & 15)));
    wr(3'd3, 32'(((il - 1) & 511) << 16 | ((ol - 1) & 511)));
    wr(3'd4, {16'd0, cv});
    wr(3'd5, av);
    wr(3'd6, td);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    do rd(3'd0, v); while (v[18]);
  endtask

  task automatic run_tx(input logic [6:0] mode, input int cl, input int al, input int dl,
                        input int ol, input int il, input logic [15:0] cv,
                        input logic [31:0] av, input logic [31:0] td,
                        input logic [127:0] rsp, input string tag);
    int p;
    logic [31:0] v;
    setup_tx(mode, cl, al, dl, ol, il, cv, av, td, rsp, tag, p);
    wr(3'd0, 32'h1 << 18);
    wait_idle();
    chk({tag, " R5 leftover bits"}, exp_q.size(), 0);
    if (mode[4]) begin
      rd(3'd7, v);
      chk({tag, " rx word"}, v, exp_rx(rsp, p, il, mode[6]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL R2 actual watchdog expired expected frames to finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int p;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", {31'd0, cs_n}, 32'd1);
    chk("R1 sclk", {31'd0, sclk}, 32'd0);
    chk("R1 mosi", {31'd0, mosi}, 32'd0);
    rd(3'd0, v); chk("R1 busy", v, 32'd0);
    rd(3'd7, v); chk("R1 rx word", v, 32'd0);

    // R6 documented example: 3b 101, 9b 0x1F3, 8b 0xCC -> 0xBF3CC
    run_tx(7'b0000111, 3, 9, 1, 8, 1, 16'h5, 32'h1F3, 32'hCC, '0, "R6");
    // R8 read: cmd, addr, 8 bits in, high-first
    run_tx(7'b0010011, 3, 9, 1, 1, 8, 16'h6, 32'h1F3, 32'h0,
           128'hF0E1D2C3B4A5968778695A4B3C2D1E0F, "R8");
    // R3 R9 R10 all phases, low-first receive, ones on MISO in the dummy window
    run_tx(7'b1011111, 8, 16, 4, 12, 32, 16'hA5, 32'h1234, 32'hABC,
           128'h0123456789ABCDEFFEDCBA9876543210, "R3 R9 R10");
    // R4 R7 no receive: dummy before data, low-first transmit
    run_tx(7'b0101111, 4, 6, 3, 24, 1, 16'h9, 32'h2A, 32'h00A1B2C3, '0, "R4 R7");
    // R6 R5 lengths beyond value width send leading zeros
    run_tx(7'b0000110, 1, 40, 1, 40, 1, 16'h0, 32'hDEADBEEF, 32'h12345678, '0, "R6 R5");
    // R6 full 16-bit command and 32-bit data
    run_tx(7'b0000101, 16, 1, 1, 32, 1, 16'hF00F, 32'h0, 32'hCAFEF00D, '0, "R6");
    // R8 long receive keeps last 32 bits
    run_tx(7'b0010000, 1, 1, 1, 1, 40, 16'h0, 32'h0, 32'h0,
           128'h5A5A_C3C3_1234_5678_9ABC_DEF0_0F0F_AAAA, "R8");
    // R9 16-bit low-first receive
    run_tx(7'b1010000, 1, 1, 1, 1, 16, 16'h0, 32'h0, 32'h0,
           128'hBEEF_0000_0000_0000_0000_0000_0000_0000, "R9");
    // R5 no phase enabled
    run_tx(7'b0000000, 1, 1, 1, 1, 1, 16'h0, 32'h0, 32'h0, '0, "R5");

    // R11 R2 second start and config writes during a running frame
    setup_tx(7'b0000101, 8, 1, 1, 32, 1, 16'h3C, 32'h0, 32'h13579BDF, '0, "R11", p);
    wr(3'd0, 32'h1 << 18);
    repeat (20) @(negedge clk);
    rd(3'd0, v); chk("R2 busy mid-frame", v, 32'h1 << 18);
    wr(3'd6, 32'hFFFFFFFF);
    wr(3'd1, 32'h1F);
    wr(3'd0, 32'h1 << 18);
    wait_idle();
    repeat (80) @(negedge clk);
    chk("R11 leftover bits", exp_q.size(), 0);
    chk("R11 cs_n idle", {31'd0, cs_n}, 32'd1);
    rd(3'd0, v); chk("R11 busy after", v, 32'd0);
    rd(3'd6, v); chk("R11 live data kept", v, 32'hFFFFFFFF);
    // R11 the new values apply to the next frame
    run_tx(7'b0000100, 1, 1, 1, 8, 1, 16'h0, 32'h0, 32'h96, '0, "R11");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule